// File: doc/BRIEF.md
# Attribute Controller Index/Data Port

This block is the colour-attribute stage of a display pipeline, configured through a single write address. Successive writes to that address take turns. The first write picks a register index, and the next write stores data into that register. An internal phase flag tracks which of the two comes next. Software resynchronises the flag by reading a separate status address, which always leaves the port expecting an index. The index write also carries a display-enable bit. While that bit is clear, the palette may be loaded and the screen shows only the border colour.

Behind the port are sixteen 6-bit palette entries and four control registers: border (overscan) colour, mode, plane enable with a status-pair select, and a horizontal pan count. The pixel path takes a stream of 4-bit plane attributes on a valid/ready interface. Each attribute is masked with the plane-enable bits and used to index the palette. The resulting 6-bit colour comes out one clock later on an output valid/ready interface. An input beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so back-pressure on `out_ready` propagates to the input without a bubble. Mode and pan values are presented as plain outputs for the downstream shifter.

Top module: `atc_port`

## Requirements
- R1: A cycle with `stat_rd` high leaves the port in index phase on the next cycle, whatever phase it was in and whether or not a write occurs in the same cycle.
- R2: From index phase, a write moves the port to data phase; a write in data phase stores data and returns the port to index phase; after reset the port is in index phase.
- R3: In an index write, bits 4:0 select the register and bit 5 sets the display enable (`disp_en_o`, 1 = display on, 0 = palette loading); `disp_en_o` is 0 after reset.
- R4: Indices 00h-0Fh are the palette entries, holding data bits 5:0 (bits 2:0 = blue, green, red at two-thirds intensity; bits 5:3 = blue, green, red at one-third intensity); a palette data write takes effect only while display enable is 0 and is otherwise ignored.
- R5: A data write to any index from 14h to 1Fh changes no register but still returns the port to index phase.
- R6: Index 10h bits 3:0 drive `mode_o` (bit 0 graphics, bit 1 monochrome attributes, bit 2 ninth-dot line replication, bit 3 blink); index 13h bits 3:0 drive `pan_o`; index 11h bits 5:0 set the border colour; all reset to 0.
- R7: An accepted attribute is ANDed with index 12h bits 3:0 (plane enable, all ones after reset) and the palette entry at that masked index appears on `out_rgb` with `out_valid` on the cycle after acceptance.
- R8: While display enable is 0, an accepted attribute produces the border colour instead of a palette lookup.
- R9: `in_ready` equals `!out_valid || out_ready`; while `out_valid` is high and `out_ready` low, `out_valid` and `out_rgb` hold their values.
- R10: `diag_o` shows two bits of `out_rgb` chosen by index 12h bits 5:4: 00 gives {bit 2, bit 0}, 01 gives {bit 1, bit 3}, 10 gives {bit 1, bit 5}, 11 gives 00 (written as {diag_o[1], diag_o[0]}).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data address |
| wr_data | input | 8 | Write data (index byte or register data) |
| stat_rd | input | 1 | Status-address read strobe; resets the phase |
| in_valid | input | 1 | Attribute input valid |
| in_ready | output | 1 | Attribute input ready |
| in_attr | input | 4 | Plane attribute |
| out_valid | output | 1 | Colour output valid |
| out_ready | input | 1 | Colour output ready |
| out_rgb | output | 6 | Looked-up colour |
| diag_o | output | 2 | Selected colour pair for status |
| disp_en_o | output | 1 | Display enable from the last index write |
| mode_o | output | 4 | Mode register bits |
| pan_o | output | 4 | Horizontal pan count |

## Verification
The bench builds the block with its defaults: sixteen palette entries, 6-bit colour and 8-bit write data. With these values every palette index, every reserved index from 14h to 1Fh, and every pattern of the 4-bit plane mask can be driven through the single write address. Output stalls are produced by a repeating `out_ready` pattern. Colour expectations are checked in order against a scoreboard. Phase resynchronisation is exercised by issuing a status read between an index write and its data write.

// File: rtl/atc_pkg.sv
package atc_pkg;
  localparam logic [4:0] IDX_MODE  = 5'h10;
  localparam logic [4:0] IDX_BORD  = 5'h11;
  localparam logic [4:0] IDX_PLANE = 5'h12;
  localparam logic [4:0] IDX_PAN   = 5'h13;

  typedef struct packed {
    logic [3:0] mode;
    logic [3:0] plane;
    logic [1:0] pair_sel;
    logic [3:0] pan;
  } ctl_t;

  function automatic logic [1:0] pick_pair(input logic [1:0] sel, input logic [5:0] c);
    case (sel)
      2'b00:   pick_pair = {c[2], c[0]};
      2'b01:   pick_pair = {c[1], c[3]};
      2'b10:   pick_pair = {c[1], c[5]};
      default: pick_pair = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/atc_phase.sv
module atc_phase #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [IDX_W-1:0]  idx_o,
  output logic              disp_en_o,
  output logic              data_we_o
);
  logic phase_q;  // 0 = expecting index, 1 = expecting data

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= 1'b0;
      idx_o     <= '0;
      disp_en_o <= 1'b0;
    end else begin
      if (wr_en) begin
        if (!phase_q) begin
          idx_o     <= wr_data[IDX_W-1:0];
          disp_en_o <= wr_data[IDX_W];
          phase_q   <= 1'b1;
        end else begin
          phase_q   <= 1'b0;
        end
      end
      if (stat_rd) phase_q <= 1'b0;
    end
  end

  assign data_we_o = wr_en && phase_q;

  p_status_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase_q);
  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stat_rd) |=> (phase_q != $past(phase_q)));
  p_data_then_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_we_o |=> !phase_q);
endmodule

// File: rtl/atc_regs.sv
module atc_regs #(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 5,
  parameter int NUM_PAL = 16,
  parameter int COLOR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       data_we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       disp_en,
  input  logic [$clog2(NUM_PAL)-1:0] rd_idx,
  output logic [COLOR_W-1:0]         rd_color,
  output logic [COLOR_W-1:0]         border_o,
  output atc_pkg::ctl_t              ctl_o
);
  import atc_pkg::*;
  localparam int ATTR_W = $clog2(NUM_PAL);

  logic [COLOR_W-1:0] pal_q [NUM_PAL];
  logic [NUM_PAL*COLOR_W-1:0] pal_flat;

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rst_n)
        pal_q[g] <= '0;
      else if (data_we && !disp_en && idx == IDX_W'(g))
        pal_q[g] <= wdata[COLOR_W-1:0];
    end
    assign pal_flat[g*COLOR_W +: COLOR_W] = pal_q[g];
  end

  assign rd_color = pal_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      border_o       <= '0;
      ctl_o.mode     <= '0;
      ctl_o.plane    <= '1;
      ctl_o.pair_sel <= '0;
      ctl_o.pan      <= '0;
    end else if (data_we) begin
      case (idx)
        IDX_MODE:  ctl_o.mode <= wdata[3:0];
        IDX_BORD:  border_o   <= wdata[COLOR_W-1:0];
        IDX_PLANE: begin
          ctl_o.plane    <= wdata[ATTR_W-1:0];
          ctl_o.pair_sel <= wdata[5:4];
        end
        IDX_PAN:   ctl_o.pan  <= wdata[3:0];
        default: ;
      endcase
    end
  end

  p_pal_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && disp_en) |=> $stable(pal_flat));
  p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx > IDX_PAN) |=> ($stable(ctl_o) && $stable(border_o) && $stable(pal_flat)));
endmodule

// File: rtl/atc_pixel.sv
module atc_pixel #(
  parameter int NUM_PAL = 16,
  parameter int COLOR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [$clog2(NUM_PAL)-1:0] in_attr,
  input  logic [$clog2(NUM_PAL)-1:0] plane_en,
  input  logic                       disp_en,
  input  logic [COLOR_W-1:0]         border,
  output logic [$clog2(NUM_PAL)-1:0] rd_idx,
  input  logic [COLOR_W-1:0]         rd_color,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [COLOR_W-1:0]         out_rgb
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign rd_idx   = in_attr & plane_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_rgb   <= disp_en ? rd_color : border;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !disp_en) |=> (out_rgb == $past(border)));
endmodule

// File: rtl/atc_port.sv
module atc_port #(
  parameter int DATA_W  = 8,
  parameter int NUM_PAL = 16,
  parameter int COLOR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               stat_rd,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [$clog2(NUM_PAL)-1:0] in_attr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [COLOR_W-1:0] out_rgb,
  output logic [1:0]         diag_o,
  output logic               disp_en_o,
  output logic [3:0]         mode_o,
  output logic [3:0]         pan_o
);
  import atc_pkg::*;
  localparam int IDX_W  = 5;
  localparam int ATTR_W = $clog2(NUM_PAL);

  logic [IDX_W-1:0]   idx;
  logic               data_we;
  logic [ATTR_W-1:0]  rd_idx;
  logic [COLOR_W-1:0] rd_color;
  logic [COLOR_W-1:0] border;
  ctl_t               ctl;

  atc_phase #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .idx_o(idx), .disp_en_o(disp_en_o), .data_we_o(data_we)
  );

  atc_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_PAL(NUM_PAL), .COLOR_W(COLOR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(idx), .wdata(wr_data),
    .disp_en(disp_en_o), .rd_idx(rd_idx), .rd_color(rd_color),
    .border_o(border), .ctl_o(ctl)
  );

  atc_pixel #(.NUM_PAL(NUM_PAL), .COLOR_W(COLOR_W)) u_pixel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_attr(in_attr), .plane_en(ctl.plane[ATTR_W-1:0]), .disp_en(disp_en_o),
    .border(border), .rd_idx(rd_idx), .rd_color(rd_color),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb)
  );

  logic [5:0] rgb6;
  if (COLOR_W >= 6) begin : g_wide
    assign rgb6 = out_rgb[5:0];
  end else begin : g_narrow
    assign rgb6 = {{(6-COLOR_W){1'b0}}, out_rgb};
  end

  assign diag_o = pick_pair(ctl.pair_sel, rgb6);
  assign mode_o = ctl.mode;
  assign pan_o  = ctl.pan;
endmodule

// File: tb/atc_port_tb.sv
module atc_port_tb;
  import atc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic stat_rd = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0] in_attr = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [5:0] out_rgb;
  logic [1:0] diag_o;
  logic disp_en_o;
  logic [3:0] mode_o, pan_o;

  int checks = 0, fails = 0, cyc = 0;
  logic stall_en = 1'b0;

  // bench model
  logic [5:0] m_pal [16];
  logic [5:0] m_bord = '0;
  logic [3:0] m_plane = 4'hF;
  logic [1:0] m_sel = '0;
  logic m_de = 1'b0;
  logic [5:0] exp_q [$];

  always #2 clk = ~clk;

  atc_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
    .in_valid(in_valid), .in_ready(in_ready), .in_attr(in_attr),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
    .diag_o(diag_o), .disp_en_o(disp_en_o), .mode_o(mode_o), .pan_o(pan_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pair_of(input logic [1:0] s, input logic [5:0] c);
    case (s)
      2'b00: return {c[2], c[0]};
      2'b01: return {c[1], c[3]};
      2'b10: return {c[1], c[5]};
      default: return 2'b00;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic status_read();
    @(posedge clk); #1 stat_rd = 1'b1;
    @(posedge clk); #1 stat_rd = 1'b0;
  endtask

  // status read, index (with display-enable bit), data; model follows R3-R6
  task automatic set_reg(input logic [4:0] idx, input logic [7:0] val, input logic de);
    status_read();
    wr({2'b00, de, idx});
    m_de = de;
    wr(val);
    if (idx < 5'h10) begin
      if (!de) m_pal[idx[3:0]] = val[5:0];
    end else if (idx == 5'h11) m_bord = val[5:0];
    else if (idx == 5'h12) begin m_plane = val[3:0]; m_sel = val[5:4]; end
  endtask

  task automatic send_px(input logic [3:0] a);
    @(posedge clk); #1 in_valid = 1'b1; in_attr = a;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    exp_q.push_back(m_de ? m_pal[a & m_plane] : m_bord);
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk); guard++;
    end
  endtask

  // back-pressure pattern
  always @(posedge clk) begin
    #1 out_ready = stall_en ? ((cyc % 5) != 3 && (cyc % 7) != 2) : 1'b1;
  end

  // monitor / scoreboard
  logic hold_pend = 1'b0;
  logic [5:0] hold_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check("R9 hold valid", int'(out_valid), 1);
        check("R9 hold data", int'(out_rgb), int'(hold_val));
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = out_rgb;
      check("R9 ready rule", int'(in_ready), int'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected output", 1, 0);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          check("R7 colour", int'(out_rgb), int'(e));
          check("R10 pair", int'(diag_o), int'(pair_of(m_sel, e)));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset out_valid", int'(out_valid), 0);
    check("R3 reset disp_en", int'(disp_en_o), 0);
    check("R6 reset mode", int'(mode_o), 0);
    check("R6 reset pan", int'(pan_o), 0);

    // R2: index then data, without status read (reset leaves index phase)
    wr(8'h13); wr(8'h05);
    @(negedge clk); check("R2 pan after first pair", int'(pan_o), 5);
    wr(8'h10); wr(8'hFB);
    @(negedge clk); check("R6 mode low bits", int'(mode_o), 4'hB);
    wr(8'h13); wr(8'h04);
    @(negedge clk); check("R2 back to index", int'(pan_o), 4);

    // R1: status read between index and data
    wr(8'h13);
    status_read();
    wr(8'h13); wr(8'h09);
    @(negedge clk); check("R1 resync pan", int'(pan_o), 9);
    check("R6 mode untouched", int'(mode_o), 4'hB);

    // R5: reserved index, data consumed
    wr(8'h15); wr(8'h0E);
    wr(8'h13); wr(8'h02);
    @(negedge clk);
    check("R5 phase consumed", int'(pan_o), 2);
    check("R5 mode unchanged", int'(mode_o), 4'hB);
    wr(8'h1F); wr(8'h03);
    @(negedge clk); check("R5 top reserved", int'(pan_o), 2);

    // R4: load palette with display off, border colour
    for (int i = 0; i < 16; i++) set_reg(5'(i), 8'((i * 7 + 3) & 8'h3F), 1'b0);
    set_reg(5'h11, 8'h2A, 1'b0);
    @(negedge clk); check("R3 display off", int'(disp_en_o), 0);

    // R8: display off shows border
    stall_en = 1'b1;
    for (int i = 0; i < 4; i++) send_px(4'(i * 5));
    drain();

    // R7: display on, full lookup
    set_reg(5'h12, 8'h0F, 1'b1);
    @(negedge clk); check("R3 display on", int'(disp_en_o), 1);
    for (int i = 0; i < 16; i++) send_px(4'(i));
    drain();

    // R4: palette write ignored while display on
    set_reg(5'h02, 8'h3F, 1'b1);
    send_px(4'h2);
    drain();

    // R7 masking and R10 selections
    set_reg(5'h12, 8'h13, 1'b1);
    send_px(4'hF); send_px(4'hC); send_px(4'h6);
    drain();
    set_reg(5'h12, 8'h2F, 1'b1);
    for (int i = 0; i < 16; i += 3) send_px(4'(i));
    drain();
    set_reg(5'h12, 8'h3F, 1'b1);
    send_px(4'h7); send_px(4'h9);
    drain();
    set_reg(5'h12, 8'h0F, 1'b1);
    stall_en = 1'b0;
    for (int i = 0; i < 8; i++) send_px(4'(15 - i));
    drain();

    check("R7 scoreboard empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule